// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the outcome of a PC-relative conditional branch. It receives the address of the branch instruction, its opcode byte (plus a second byte for the longer forms), an 8-bit signed offset, the instruction length and the four condition flags. It reports whether the branch is taken and which address the program counter takes next.

The condition is decoded from the opcode. Eight short two-byte opcodes test signed and unsigned relations built from the flags. One short opcode branches unconditionally. A three-byte escape form tests single flags. A taken branch goes to the instruction's own address plus the sign-extended offset. Any other outcome falls through to the address plus the length. The decision logic is combinational. A parameter chooses whether the two results leave through a pipeline register or straight from the logic.

Top module: `branch_resolver`

## Requirements
- R1: With the output register enabled (default), a clock edge with `rst_n` low clears `taken_o` and `next_pc_o` to zero; results of inputs applied at one rising edge appear after that edge.
- R2: Opcode 0xC0 is taken when N != V. 0xC1 is taken when Z = 0 and N = V. 0xC2 is taken when N = V. 0xC3 is taken when Z = 1 or N != V.
- R3: Opcode 0xC4 is taken when C = 1. 0xC5 is taken when C = 0 and Z = 0. 0xC6 is taken when C = 0. 0xC7 is taken when C = 1 or Z = 1.
- R4: Opcode 0xCA is always taken, whatever the flags.
- R5: Opcode 0xF8 with second byte 0xE8, 0xE9, 0xEA or 0xEB is taken when V = 0, V = 1, C = 0 or N = 1 respectively.
- R6: When taken, `next_pc_o` equals `pc_i` plus the offset sign-extended from bit 7, modulo 2^PC_W.
- R7: When not taken, `next_pc_o` equals `pc_i` plus `len_i`, modulo 2^PC_W.
- R8: Any other first byte, and 0xF8 with any other second byte, gives not taken with the fall-through address of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | PC_W | Address of the branch instruction |
| opc_i | input | 8 | First opcode byte |
| ext_i | input | 8 | Second opcode byte (used after 0xF8) |
| disp_i | input | 8 | Signed branch offset |
| len_i | input | 2 | Instruction length in bytes (2 or 3) |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | PC_W | Next program counter |

## Verification
The condition decision and address wraparound can meet in one cycle. A taken branch near the top of the address space with a forward offset, or near zero with a backward one, must both pick the target and wrap it. A not-taken branch at the last addresses must wrap the fall-through. Directed vectors at 0xFFFFFFFF and 0x00000000 are combined with each condition sense. Random vectors spread the PC over the full range. Every result is compared, one edge later, with a model that builds each relation from the flags on its own.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int PC_W    = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc_i,
  input  logic [7:0]      opc_i,
  input  logic [7:0]      ext_i,
  input  logic [7:0]      disp_i,
  input  logic [1:0]      len_i,
  input  logic            flag_z_i,
  input  logic            flag_n_i,
  input  logic            flag_c_i,
  input  logic            flag_v_i,
  output logic            taken_o,
  output logic [PC_W-1:0] next_pc_o
);

  localparam int SEXT_W = PC_W - 8;

  logic            signed_lt;
  logic            cond;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] fall;
  logic [PC_W-1:0] nxt;

  assign signed_lt = flag_n_i ^ flag_v_i;

  always_comb begin
    unique case (opc_i)
      8'hC0:   cond = signed_lt;
      8'hC1:   cond = !flag_z_i && !signed_lt;
      8'hC2:   cond = !signed_lt;
      8'hC3:   cond = flag_z_i || signed_lt;
      8'hC4:   cond = flag_c_i;
      8'hC5:   cond = !flag_c_i && !flag_z_i;
      8'hC6:   cond = !flag_c_i;
      8'hC7:   cond = flag_c_i || flag_z_i;
      8'hCA:   cond = 1'b1;
      8'hF8: begin
        unique case (ext_i)
          8'hE8:   cond = !flag_v_i;
          8'hE9:   cond = flag_v_i;
          8'hEA:   cond = !flag_c_i;
          8'hEB:   cond = flag_n_i;
          default: cond = 1'b0;
        endcase
      end
      default: cond = 1'b0;
    endcase
  end

  assign target = pc_i + {{SEXT_W{disp_i[7]}}, disp_i};
  assign fall   = pc_i + PC_W'(len_i);
  assign nxt    = cond ? target : fall;

  generate
    if (OUT_REG) begin : g_reg
      logic            taken_q;
      logic [PC_W-1:0] pc_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          taken_q <= 1'b0;
          pc_q    <= '0;
        end else begin
          taken_q <= cond;
          pc_q    <= nxt;
        end
      end

      assign taken_o   = taken_q;
      assign next_pc_o = pc_q;

      // R1
      reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!taken_o && next_pc_o == '0));

      // R4
      always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc_i == 8'hCA |=> taken_o &&
          next_pc_o == $past(pc_i) + {{SEXT_W{$past(disp_i[7])}}, $past(disp_i)});

      // R2
      less_than_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc_i == 8'hC0 |=> taken_o == ($past(flag_n_i) != $past(flag_v_i)));

      // R7
      fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (taken_o || next_pc_o == $past(pc_i) + PC_W'($past(len_i))));

      // R8
      unassigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_i[7:4] != 4'hC && opc_i != 8'hF8) |=> !taken_o);
    end else begin : g_comb
      assign taken_o   = cond;
      assign next_pc_o = nxt;
    end
  endgenerate

endmodule

// File: tb/test_branch_resolver.sv
module test_branch_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic [7:0]  opc = '0, ext = '0, disp = '0;
  logic [1:0]  len = 2'd2;
  logic        fz = 0, fn = 0, fc = 0, fv = 0;
  logic        taken;
  logic [31:0] npc;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  branch_resolver i_branch_resolver (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .opc_i(opc), .ext_i(ext),
    .disp_i(disp), .len_i(len), .flag_z_i(fz), .flag_n_i(fn),
    .flag_c_i(fc), .flag_v_i(fv), .taken_o(taken), .next_pc_o(npc)
  );

  function automatic bit model_taken(input logic [7:0] o, input logic [7:0] e,
                                     input bit z, input bit n, input bit c, input bit v);
    bit ge = (n == v);
    if (o == 8'hC0) return !ge;
    if (o == 8'hC1) return ge && !z;
    if (o == 8'hC2) return ge;
    if (o == 8'hC3) return !(ge && !z);
    if (o == 8'hC4) return c;
    if (o == 8'hC5) return !(c || z);
    if (o == 8'hC6) return !c;
    if (o == 8'hC7) return c || z;
    if (o == 8'hCA) return 1'b1;
    if (o == 8'hF8) begin
      if (e == 8'hE8) return !v;
      if (e == 8'hE9) return v;
      if (e == 8'hEA) return !c;
      if (e == 8'hEB) return n;
    end
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic [7:0] o, input logic [7:0] e, input bit t);
    if (o inside {[8'hC0:8'hC3]}) return t ? "R2/R6" : "R2/R7";
    if (o inside {[8'hC4:8'hC7]}) return t ? "R3/R6" : "R3/R7";
    if (o == 8'hCA) return "R4/R6";
    if (o == 8'hF8 && e inside {[8'hE8:8'hEB]}) return t ? "R5/R6" : "R5/R7";
    return "R8";
  endfunction

  task automatic apply(input logic [31:0] p, input logic [7:0] o, input logic [7:0] e,
                       input logic [7:0] d, input logic [1:0] l,
                       input bit z, input bit n, input bit c, input bit v);
    bit          et;
    logic [31:0] ep;
    et = model_taken(o, e, z, n, c, v);
    ep = et ? p + 32'(signed'(d)) : p + 32'(l);
    pc = p; opc = o; ext = e; disp = d; len = l;
    fz = z; fn = n; fc = c; fv = v;
    @(negedge clk);
    vectors++;
    if (taken !== et || npc !== ep) begin
      errors++;
      $display("FAIL %s op=%h/%h: got taken=%0b pc=%h, expected taken=%0b pc=%h",
               tag_of(o, e, et), o, e, taken, npc, et, ep);
    end
  endtask

  initial begin
    #300000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] short_ops [9] = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hCA};
    void'($urandom(32'd1234));
    pc = 32'h1234_5678; opc = 8'hCA;
    repeat (3) @(negedge clk);
    vectors++;
    // R1: reset clears registered outputs
    if (taken !== 1'b0 || npc !== 32'h0) begin
      errors++;
      $display("FAIL R1: got taken=%0b pc=%h, expected taken=0 pc=00000000", taken, npc);
    end
    rst_n = 1'b1;

    // R6 wraparound forward and backward, R4 always taken
    apply(32'hFFFF_FFFF, 8'hCA, 8'h00, 8'h05, 2'd2, 0, 0, 0, 0);
    apply(32'h0000_0000, 8'hCA, 8'h00, 8'h80, 2'd2, 1, 1, 1, 1);
    // R7 wraparound of fall-through
    apply(32'hFFFF_FFFE, 8'hF8, 8'hE9, 8'h10, 2'd3, 0, 0, 0, 0);
    apply(32'hFFFF_FFFF, 8'hC4, 8'h00, 8'h7F, 2'd2, 0, 0, 0, 0);
    // R2 signed relations, equality edge
    apply(32'h0000_1000, 8'hC1, 8'h00, 8'hFE, 2'd2, 1, 0, 0, 0);
    apply(32'h0000_1000, 8'hC3, 8'h00, 8'hFE, 2'd2, 1, 0, 0, 0);
    apply(32'h0000_1000, 8'hC2, 8'h00, 8'hFE, 2'd2, 0, 1, 0, 1);
    // R3 unsigned relations
    apply(32'h0000_2000, 8'hC5, 8'h00, 8'h20, 2'd2, 1, 0, 0, 0);
    apply(32'h0000_2000, 8'hC7, 8'h00, 8'h20, 2'd2, 0, 0, 1, 0);
    // R5 extended forms
    apply(32'h0000_3000, 8'hF8, 8'hEB, 8'h90, 2'd3, 0, 1, 0, 0);
    apply(32'h0000_3000, 8'hF8, 8'hEA, 8'h90, 2'd3, 0, 0, 1, 0);
    // R8 unassigned opcodes and escape with bad second byte
    apply(32'h0000_4000, 8'hC8, 8'h00, 8'h10, 2'd2, 1, 1, 1, 1);
    apply(32'h0000_4000, 8'hF8, 8'hEC, 8'h10, 2'd3, 0, 1, 0, 0);
    apply(32'h0000_4000, 8'hCB, 8'h00, 8'h10, 2'd2, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int          sel = $urandom_range(0, 3);
      logic [7:0]  o, e;
      logic [1:0]  l;
      logic [31:0] r = $urandom;
      if (sel <= 1) begin
        o = short_ops[$urandom_range(0, 8)]; e = 8'($urandom); l = 2'd2;
      end else if (sel == 2) begin
        o = 8'hF8; e = 8'hE8 + 8'($urandom_range(0, 4)); l = 2'd3;
      end else begin
        o = 8'($urandom); e = 8'($urandom); l = 2'($urandom_range(2, 3));
      end
      apply($urandom, o, e, 8'($urandom), l, r[0], r[1], r[2], r[3]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule